// File: doc/BRIEF.md
# Fractional-N PLL Rate Configuration Calculator

This block turns a requested VCO frequency, given in Hz, into the full set of configuration fields that a fractional-N PLL needs. A one-cycle `start` pulse with `reverse` low launches the forward calculation. The requested rate is first clamped to the legal VCO range. The block then picks integer or fractional feedback and derives the divider fields, the 16-bit fractional seed, the loop-filter resistance code and the two calibration bytes. All divisions go through one shared restoring divider that produces one quotient bit per cycle. The result therefore appears after a bounded, rate-independent number of cycles, marked by a one-cycle `done` pulse.

A `start` with `reverse` high runs the reverse calculation instead. It rebuilds the VCO rate from a set of programmed fields presented on the `fld_*` inputs and answers one cycle later on `vco_rate`. Software can use this to read back the rate that a saved configuration actually produces.

All result outputs are registers. They change only in the cycle in which `done` is high and hold their values until the next finished calculation.

Top module: `pll_rate_calc`

## Requirements
- R1: The requested rate is clamped to the range MIN_HZ..MAX_HZ (350 MHz..750 MHz by default) before any other use. A rate below the range behaves as MIN_HZ and a rate above it behaves as MAX_HZ.
- R2: When the clamped rate is an exact multiple of REF_HZ (19.2 MHz), the block selects integer mode. In that case `int_mode`=1, `dbl_en`=0, `byp_div` = (rate/REF_HZ − 1) mod 64, `dc_off`=0, both seed bytes are 0 and `gen_rate` equals the clamped rate.
- R3: Any other clamped rate selects fractional mode. Let D = floor(rate / (REF_HZ/500)). Then `int_mode`=0, `dbl_en`=1, `byp_div`=0, `dc_off` = (floor(D/1000) mod 64 − 1) mod 64 and `gen_rate` = D·(REF_HZ/500).
- R4: In fractional mode the seed S = floor((D mod 1000)·65536/1000). Bits 7:0 of S appear on `seed_lo` and bits 15:8 on `seed_hi`.
- R5: `lpf_code` is the code of the first threshold, searched in ascending order, that is at least the clamped rate. The thresholds and codes are 479.5M→8, 480M→11, 575.5M→8, 576M→12, 610.5M→8, 659.5M→9, 671.5M→10, 672M→14, 708.5M→10 and 750M→11. `lpf_err` is 1 with code 0 only if the rate lies above every threshold, and it is 0 for all rates inside the clamp range.
- R6: With M = floor(`gen_rate`/1e6), `cal_hi` = floor(M/256) mod 256 and `cal_lo` = M mod 256. These equal floor(gen/256 MHz) and floor((gen mod 256 MHz)/1 MHz), each truncated to 8 bits.
- R7: In the reverse calculation the reference R is REF_HZ, or 2·REF_HZ when `fld_dbl`=1. With `fld_int`=1 the result is `vco_rate` = R·(`fld_bdiv`+1). With `fld_int`=0 it is R·(`fld_dc`+1) + floor(R·`fld_seed`/65536). The result appears with `done` one cycle after `start`, and the forward outputs are left unchanged.
- R8: `done` is high for exactly one cycle per accepted start. A forward calculation finishes within 180 cycles of `start`. No result output changes in a cycle in which `done` is low.
- R9: A `start` that arrives while a forward calculation is running is ignored. The running calculation finishes with the fields of the rate it began with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation when idle |
| reverse | input | 1 | 1 selects the reverse calculation at start |
| req_rate | input | 32 | Requested VCO rate in Hz |
| fld_dbl | input | 1 | Reverse input: reference doubler enable |
| fld_int | input | 1 | Reverse input: integer mode |
| fld_bdiv | input | 6 | Reverse input: integer bypass divider |
| fld_dc | input | 6 | Reverse input: fractional DC offset |
| fld_seed | input | 16 | Reverse input: fractional seed |
| done | output | 1 | One-cycle completion pulse |
| dbl_en | output | 1 | Reference doubler enable |
| int_mode | output | 1 | Integer (1) or fractional (0) feedback |
| byp_div | output | 6 | Integer bypass divider field |
| dc_off | output | 6 | Fractional DC offset field |
| seed_lo | output | 8 | Fractional seed bits 7:0 |
| seed_hi | output | 8 | Fractional seed bits 15:8 |
| lpf_code | output | 4 | Loop-filter resistance code |
| lpf_err | output | 1 | Rate above every loop-filter threshold |
| cal_lo | output | 8 | Calibration byte: MHz within the 256 MHz step |
| cal_hi | output | 8 | Calibration byte: 256 MHz steps |
| gen_rate | output | 32 | Rate the programmed fields generate, in Hz |
| vco_rate | output | 32 | Reverse calculation result, in Hz |

## Verification
The forward path is swept over every multiple of the reference from 15 to 42. This separates integer mode from fractional mode on both sides of the clamp limits, because 288 MHz and 768 MHz must fall back to the clamped fractional answers. A fine sweep with an odd step over 340 to 760 MHz exercises the seed rounding and both calibration bytes. Probes at each loop-filter threshold and one Hz on either side of it confirm that the search is inclusive and ordered. The reverse path is swept over every divider value with both doubler settings and several seeds, including 0 and the maximum, which separates the integer and fractional formulas and the truncation of the seed product. A start injected mid-computation shows whether a busy calculation can be disturbed.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

    localparam int RATE_W = 32;
    localparam int LPF_N  = 10;

    typedef enum logic [2:0] {
        S_IDLE, S_REF, S_FB, S_INT, S_SEED, S_MHZ
    } calc_st_e;

    localparam logic [RATE_W-1:0] LPF_THR [LPF_N] = '{
        32'd479_500_000, 32'd480_000_000, 32'd575_500_000, 32'd576_000_000,
        32'd610_500_000, 32'd659_500_000, 32'd671_500_000, 32'd672_000_000,
        32'd708_500_000, 32'd750_000_000
    };
    localparam logic [3:0] LPF_CODE [LPF_N] = '{
        4'd8, 4'd11, 4'd8, 4'd12, 4'd8, 4'd9, 4'd10, 4'd14, 4'd10, 4'd11
    };

    typedef struct packed {
        logic [3:0] code;
        logic       err;
    } lpf_sel_t;

    // scanned from the top down so the lowest matching entry wins
    function automatic lpf_sel_t lpf_pick(input logic [RATE_W-1:0] r);
        lpf_sel_t s;
        s.code = 4'd0;
        s.err  = 1'b1;
        for (int i = LPF_N - 1; i >= 0; i--) begin
            if (r <= LPF_THR[i]) begin
                s.code = LPF_CODE[i];
                s.err  = 1'b0;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          fin;
        logic [CW-1:0] cnt;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
        logic [W-1:0]  dvs;
    } div_t;

    div_t q, d;
    logic [W:0] shifted;

    always_comb begin
        d       = q;
        d.fin   = 1'b0;
        shifted = {q.rem, q.quo[W-1]};
        if (go) begin
            d.busy = 1'b1;
            d.cnt  = CW'(W);
            d.quo  = dividend;
            d.rem  = '0;
            d.dvs  = divisor;
        end else if (q.busy) begin
            if (shifted >= {1'b0, q.dvs}) begin
                d.rem = W'(shifted - {1'b0, q.dvs});
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = shifted[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin = q.fin;
    assign quo = q.quo;
    assign rem = q.rem;
endmodule

// File: rtl/lpf_lookup.sv
module lpf_lookup
    import pll_calc_pkg::*;
(
    input  logic [RATE_W-1:0] rate,
    output logic [3:0]        code,
    output logic              err
);
    lpf_sel_t sel;
    always_comb begin
        sel  = lpf_pick(rate);
        code = sel.code;
        err  = sel.err;
    end
endmodule

// File: rtl/rev_rate.sv
module rev_rate #(
    parameter int RW     = 32,
    parameter int REF_HZ = 19_200_000
) (
    input  logic          dbl,
    input  logic          int_m,
    input  logic [5:0]    bdiv,
    input  logic [5:0]    dc,
    input  logic [15:0]   seed,
    output logic [RW-1:0] rate
);
    localparam logic [RW-1:0] REF1 = RW'(REF_HZ);
    localparam logic [RW-1:0] REF2 = RW'(2 * REF_HZ);

    logic [RW-1:0]      r;
    logic [RW+15:0]     frac_p;
    logic [RW-1:0]      whole;

    always_comb begin
        r      = dbl ? REF2 : REF1;
        frac_p = (RW+16)'(r) * (RW+16)'(seed);
        if (int_m) begin
            whole = RW'(r * RW'({1'b0, bdiv} + 7'd1));
            rate  = whole;
        end else begin
            whole = RW'(r * RW'({1'b0, dc} + 7'd1));
            rate  = whole + frac_p[RW+15:16];
        end
    end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_calc_pkg::*;
#(
    parameter int REF_HZ = 19_200_000,
    parameter int MIN_HZ = 350_000_000,
    parameter int MAX_HZ = 750_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        reverse,
    input  logic [31:0] req_rate,
    input  logic        fld_dbl,
    input  logic        fld_int,
    input  logic [5:0]  fld_bdiv,
    input  logic [5:0]  fld_dc,
    input  logic [15:0] fld_seed,
    output logic        done,
    output logic        dbl_en,
    output logic        int_mode,
    output logic [5:0]  byp_div,
    output logic [5:0]  dc_off,
    output logic [7:0]  seed_lo,
    output logic [7:0]  seed_hi,
    output logic [3:0]  lpf_code,
    output logic        lpf_err,
    output logic [7:0]  cal_lo,
    output logic [7:0]  cal_hi,
    output logic [31:0] gen_rate,
    output logic [31:0] vco_rate
);
    localparam logic [RATE_W-1:0] REF_V   = RATE_W'(REF_HZ);
    localparam logic [RATE_W-1:0] FB_STEP = RATE_W'(REF_HZ / 500);
    localparam logic [RATE_W-1:0] LO_V    = RATE_W'(MIN_HZ);
    localparam logic [RATE_W-1:0] HI_V    = RATE_W'(MAX_HZ);
    localparam logic [RATE_W-1:0] MHZ     = RATE_W'(1_000_000);
    localparam logic [RATE_W-1:0] THOU    = RATE_W'(1000);

    typedef struct packed {
        calc_st_e          st;
        logic              go;
        logic [RATE_W-1:0] dvd;
        logic [RATE_W-1:0] dvs;
        logic [RATE_W-1:0] rate;
        // working copies, published only on completion
        logic              w_int;
        logic [5:0]        w_bdiv;
        logic [5:0]        w_dc;
        logic [15:0]       w_seed;
        logic [3:0]        w_lpf;
        logic              w_lerr;
        logic [RATE_W-1:0] w_gen;
        // published results
        logic              done;
        logic              o_dbl;
        logic              o_int;
        logic [5:0]        o_bdiv;
        logic [5:0]        o_dc;
        logic [15:0]       o_seed;
        logic [3:0]        o_lpf;
        logic              o_lerr;
        logic [15:0]       o_cal;
        logic [RATE_W-1:0] o_gen;
        logic [RATE_W-1:0] o_vco;
    } calc_t;

    calc_t q, d;

    logic [RATE_W-1:0] clamped;
    logic [3:0]        lk_code;
    logic              lk_err;
    logic [RATE_W-1:0] rev_v;
    logic              dv_fin;
    logic [RATE_W-1:0] dv_quo;
    logic [RATE_W-1:0] dv_rem;

    always_comb begin
        if (req_rate < LO_V)      clamped = LO_V;
        else if (req_rate > HI_V) clamped = HI_V;
        else                      clamped = req_rate;
    end

    lpf_lookup u_lpf (.rate(clamped), .code(lk_code), .err(lk_err));

    rev_rate #(.RW(RATE_W), .REF_HZ(REF_HZ)) u_rev (
        .dbl(fld_dbl), .int_m(fld_int), .bdiv(fld_bdiv),
        .dc(fld_dc), .seed(fld_seed), .rate(rev_v)
    );

    seq_divider #(.W(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(q.go), .dividend(q.dvd),
        .divisor(q.dvs), .fin(dv_fin), .quo(dv_quo), .rem(dv_rem)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: if (start) begin
                if (reverse) begin
                    d.o_vco = rev_v;
                    d.done  = 1'b1;
                end else begin
                    d.rate   = clamped;
                    d.w_lpf  = lk_code;
                    d.w_lerr = lk_err;
                    d.go     = 1'b1;
                    d.dvd    = clamped;
                    d.dvs    = REF_V;
                    d.st     = S_REF;
                end
            end
            S_REF: if (dv_fin) begin
                d.go = 1'b1;
                if (dv_rem == '0) begin
                    d.w_int  = 1'b1;
                    d.w_bdiv = 6'(dv_quo[5:0] - 6'd1);
                    d.w_dc   = '0;
                    d.w_seed = '0;
                    d.w_gen  = q.rate;
                    d.dvd    = q.rate;
                    d.dvs    = MHZ;
                    d.st     = S_MHZ;
                end else begin
                    d.w_int  = 1'b0;
                    d.w_bdiv = '0;
                    d.dvd    = q.rate;
                    d.dvs    = FB_STEP;
                    d.st     = S_FB;
                end
            end
            S_FB: if (dv_fin) begin
                d.w_gen = RATE_W'(dv_quo * FB_STEP);
                d.go    = 1'b1;
                d.dvd   = dv_quo;
                d.dvs   = THOU;
                d.st    = S_INT;
            end
            S_INT: if (dv_fin) begin
                d.w_dc = 6'(dv_quo[5:0] - 6'd1);
                d.go   = 1'b1;
                d.dvd  = {dv_rem[15:0], 16'd0};
                d.dvs  = THOU;
                d.st   = S_SEED;
            end
            S_SEED: if (dv_fin) begin
                d.w_seed = dv_quo[15:0];
                d.go     = 1'b1;
                d.dvd    = q.w_gen;
                d.dvs    = MHZ;
                d.st     = S_MHZ;
            end
            S_MHZ: if (dv_fin) begin
                d.o_dbl  = ~q.w_int;
                d.o_int  = q.w_int;
                d.o_bdiv = q.w_bdiv;
                d.o_dc   = q.w_dc;
                d.o_seed = q.w_seed;
                d.o_lpf  = q.w_lpf;
                d.o_lerr = q.w_lerr;
                d.o_cal  = dv_quo[15:0];
                d.o_gen  = q.w_gen;
                d.done   = 1'b1;
                d.st     = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.o_int <= 1'b1;
            q.w_int <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign dbl_en   = q.o_dbl;
    assign int_mode = q.o_int;
    assign byp_div  = q.o_bdiv;
    assign dc_off   = q.o_dc;
    assign seed_lo  = q.o_seed[7:0];
    assign seed_hi  = q.o_seed[15:8];
    assign lpf_code = q.o_lpf;
    assign lpf_err  = q.o_lerr;
    assign cal_lo   = q.o_cal[7:0];
    assign cal_hi   = q.o_cal[15:8];
    assign gen_rate = q.o_gen;
    assign vco_rate = q.o_vco;
endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
    parameter int MAX_HZ = 750_000_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        dbl_en,
    input logic        int_mode,
    input logic [5:0]  byp_div,
    input logic [5:0]  dc_off,
    input logic [7:0]  seed_lo,
    input logic [7:0]  seed_hi,
    input logic [3:0]  lpf_code,
    input logic        lpf_err,
    input logic [7:0]  cal_lo,
    input logic [7:0]  cal_hi,
    input logic [31:0] gen_rate,
    input logic [31:0] vco_rate
);
    localparam logic [7:0]  CAL_HI_MAX = 8'((MAX_HZ / 1_000_000) / 256);
    localparam logic [31:0] GEN_MAX    = 32'(MAX_HZ);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({dbl_en, int_mode, byp_div, dc_off, seed_lo, seed_hi,
                           lpf_code, lpf_err, cal_lo, cal_hi, gen_rate, vco_rate}));

    p_int_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode |-> (!dbl_en && dc_off == 6'd0 && seed_lo == 8'd0 && seed_hi == 8'd0));

    p_frac_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !int_mode |-> (dbl_en && byp_div == 6'd0));

    p_gen_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gen_rate <= GEN_MAX);

    p_cal_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_hi <= CAL_HI_MAX);

    p_no_lpf_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && int_mode) |-> !lpf_err);
endmodule

bind pll_rate_calc pll_rate_calc_chk #(.MAX_HZ(MAX_HZ)) u_chk (.*);

// File: tb/pll_rate_calc_test.sv
module pll_rate_calc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        reverse = 1'b0;
    logic [31:0] req_rate = '0;
    logic        fld_dbl = 1'b0;
    logic        fld_int = 1'b0;
    logic [5:0]  fld_bdiv = '0;
    logic [5:0]  fld_dc = '0;
    logic [15:0] fld_seed = '0;
    logic        done, dbl_en, int_mode, lpf_err;
    logic [5:0]  byp_div, dc_off;
    logic [7:0]  seed_lo, seed_hi, cal_lo, cal_hi;
    logic [3:0]  lpf_code;
    logic [31:0] gen_rate, vco_rate;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pll_rate_calc uut (.*);

    longint unsigned thr [10] = '{479500000, 480000000, 575500000, 576000000,
        610500000, 659500000, 671500000, 672000000, 708500000, 750000000};
    int codes [10] = '{8, 11, 8, 12, 8, 9, 10, 14, 10, 11};

    task automatic chk(input string req, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic fwd(input longint unsigned r, input bit poke);
        longint unsigned c, dv, ip, sd, gen, m, lc, le;
        int n;
        bit im;
        logic [31:0] g_hold;
        c = (r < 350000000) ? 350000000 : (r > 750000000) ? 750000000 : r;
        im = (c % 19200000) == 0;
        lc = 0; le = 1;
        for (int i = 9; i >= 0; i--) if (c <= thr[i]) begin lc = codes[i]; le = 0; end
        @(negedge clk);
        req_rate = r[31:0]; reverse = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 400) begin
            if (poke && n == 4) begin start = 1'b1; reverse = 1'b1; req_rate = 32'd600000000; end
            if (poke && n == 6) begin start = 1'b0; reverse = 1'b0; end
            @(negedge clk);
            n++;
        end
        chk("R8 done seen", done, 1);
        chk("R8 latency bound", n <= 180, 1);
        if (im) begin
            gen = c;
            chk("R2 int_mode", int_mode, 1);
            chk("R2 dbl_en", dbl_en, 0);
            chk("R2 byp_div", byp_div, ((c / 19200000) - 1) & 63);
            chk("R2 dc_off", dc_off, 0);
            chk("R2 seed", {seed_hi, seed_lo}, 0);
        end else begin
            dv = c / 38400;
            ip = dv / 1000;
            sd = ((dv % 1000) << 16) / 1000;
            gen = dv * 38400;
            chk("R3 int_mode", int_mode, 0);
            chk("R3 dbl_en", dbl_en, 1);
            chk("R3 byp_div", byp_div, 0);
            chk("R3 dc_off", dc_off, (ip - 1) & 63);
            chk("R4 seed_lo", seed_lo, sd & 255);
            chk("R4 seed_hi", seed_hi, (sd >> 8) & 255);
        end
        chk(poke ? "R9 gen_rate" : "R1 gen_rate", gen_rate, gen);
        chk("R5 lpf_code", lpf_code, lc);
        chk("R5 lpf_err", lpf_err, le);
        m = gen / 1000000;
        chk("R6 cal_hi", cal_hi, (m >> 8) & 255);
        chk("R6 cal_lo", cal_lo, m & 255);
        g_hold = gen_rate;
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
        chk("R8 outputs hold", gen_rate, g_hold);
    endtask

    task automatic rev(input bit db, input bit im, input int bd, input int dc,
                       input int sd);
        longint unsigned rf, e;
        int n;
        logic [31:0] g_hold;
        rf = db ? 38400000 : 19200000;
        if (im) e = rf * (bd + 1);
        else    e = rf * (dc + 1) + ((rf * sd) >> 16);
        e = e & 64'hFFFF_FFFF;
        g_hold = gen_rate;
        @(negedge clk);
        fld_dbl = db; fld_int = im; fld_bdiv = 6'(bd); fld_dc = 6'(dc);
        fld_seed = 16'(sd); reverse = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; reverse = 1'b0;
        chk("R7 done after one cycle", done, 1);
        wait_done(n);
        chk("R7 vco_rate", vco_rate, e);
        chk("R7 forward outputs kept", gen_rate, g_hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset done", done, 0);
        chk("R2 reset int_mode", int_mode, 1);
        chk("R1 reset gen_rate", gen_rate, 0);
        rst_n = 1'b1;
        // integer multiples across and beyond the clamp range
        for (int k = 15; k <= 42; k++) fwd(longint'(k) * 19200000, 1'b0);
        // fine sweep with an odd step
        for (longint unsigned r = 340000000; r <= 760000000; r += 3333331) fwd(r, 1'b0);
        // loop-filter thresholds and neighbours
        for (int i = 0; i < 10; i++) begin
            fwd(thr[i] - 1, 1'b0);
            fwd(thr[i], 1'b0);
            if (i < 9) fwd(thr[i] + 1, 1'b0);
        end
        fwd(0, 1'b0);
        fwd(64'hFFFF_FFFF, 1'b0);
        // start while busy must not disturb the run
        fwd(512345678, 1'b1);
        fwd(460800000, 1'b1);
        // reverse sweep
        for (int db = 0; db < 2; db++)
            for (int bd = 0; bd < 64; bd++) rev(db[0], 1'b1, bd, 0, 0);
        for (int db = 0; db < 2; db++)
            for (int dc = 0; dc < 64; dc++) begin
                rev(db[0], 1'b0, 0, dc, 0);
                rev(db[0], 1'b0, 0, dc, 1);
                rev(db[0], 1'b0, 0, dc, 32768);
                rev(db[0], 1'b0, 0, dc, 65535);
            end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule